// File: doc/BRIEF.md
# Cross-Domain Mailbox Flags

This block watches host bus cycles in the host bus clock domain, where the bus command strobe is the capture edge. For each mailbox register, such as the attention and command registers, it sends a "written" event into the main clock domain and turns that event into a sticky full flag. Local firmware reads the flag and later clears it. Along with each flag, the main domain receives the data word the host wrote and a set pulse one cycle long.

The address match is registered in the bus domain on the command strobe itself. Each mailbox keeps a toggle flop that flips once for every matching host write. That flop output goes straight into the first synchronizer stage in the main domain, with no gates between the two flops. A slow address comparator can therefore never leak a runt pulse from the previous address across the boundary. In the main domain a three-flop shift register synchronizes the toggle, and its last two stages are compared to produce one set event per host write. The word is stored on the bus side with the same strobe. It is copied to the main-domain output on the edge where the flag sets, so firmware never sees a word older than the flag.

Top module: `mbox_xdomain_flags`

## Requirements
- R1: While rst_ni is low, every full flag, set pulse and data output is 0.
- R2: A strobe rise with bus_op_i=1, bus_wr_ni=0 and bus_addr_i equal to a mailbox's address gives exactly one set pulse for that mailbox. With the default addresses, 0x2 is mailbox 0 (attention) and 0x3 is mailbox 1 (command). The pulse lasts one main clock cycle and is visible after the second main clock edge following the strobe rise.
- R3: The full flag rises on the main clock edge after the set pulse and stays high until it is cleared.
- R4: A read cycle (bus_wr_ni=1) to a mailbox address never pulses or sets that mailbox.
- R5: A cycle with bus_op_i=0 never pulses or sets any mailbox, whatever the address and direction.
- R6: A write to any address other than a mailbox's own leaves that mailbox's pulse, flag and data unchanged.
- R7: A high clr_i bit clears the matching full flag on the next main clock edge. It has no effect on a flag that is already low.
- R8: When a set event and a clear reach a flag on the same edge, the flag ends up set.
- R9: On the edge where a flag sets, data_o for that mailbox loads the most recent word written to it. At all other edges the word holds, including edges where the flag is cleared.
- R10: Writes on consecutive strobes (the attention write followed at once by a command write, or two writes to one mailbox) each produce their own set pulse. A word stays readable however late firmware clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| bus_cmd_i | input | 1 | Host command strobe; its rising edge captures a bus cycle |
| bus_op_i | input | 1 | Bus operation valid |
| bus_wr_ni | input | 1 | Direction, low for a write |
| bus_addr_i | input | ADDR_W | Host register address |
| bus_data_i | input | DATA_W | Host write data |
| clr_i | input | N_MBOX | Firmware clear strobes, one per mailbox |
| set_pulse_o | output | N_MBOX | One-cycle set events in the main domain |
| full_o | output | N_MBOX | Sticky full flags |
| data_o | output | N_MBOX*DATA_W | Captured words, mailbox k at bits [k*DATA_W +: DATA_W] |

## Verification
Two functions can meet at a flag on the same main clock edge: the set that arrives from the synchronizer, and the clear from firmware. The bench provokes this by timing clr_i to the cycle in which the set pulse is visible, after an earlier write has already filled the flag. The flag must stay high and the word must change to the new one, which would show at the ports if the clear won. A second collision is back-to-back strobes to one mailbox or to both. The reference model expects a separate pulse for each write in consecutive cycles.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // depth of the main-domain shift register; last two stages form the edge compare
  localparam int unsigned SYNC_DEPTH = 3;
endpackage

// File: rtl/mbox_bus_capture.sv
module mbox_bus_capture #(
  parameter int unsigned       ADDR_W  = 4,
  parameter int unsigned       DATA_W  = 16,
  parameter logic [ADDR_W-1:0] MY_ADDR = '0
) (
  input  logic              bus_cmd_i,
  input  logic              rst_ni,
  input  logic              bus_op_i,
  input  logic              bus_wr_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              req_tgl_o,
  output logic [DATA_W-1:0] word_o
);
  logic              hit;
  logic              tgl_q;
  logic [DATA_W-1:0] word_q;

  assign hit = bus_op_i & ~bus_wr_ni & (bus_addr_i == MY_ADDR);

  // decode is resolved before the strobe edge; only flop outputs leave this domain
  always_ff @(posedge bus_cmd_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgl_q  <= 1'b0;
      word_q <= '0;
    end else if (hit) begin
      tgl_q  <= ~tgl_q;
      word_q <= bus_data_i;
    end
  end

  assign req_tgl_o = tgl_q;
  assign word_o    = word_q;
endmodule

// File: rtl/mbox_flag_sync.sv
module mbox_flag_sync #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_tgl_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              clr_i,
  output logic              set_o,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  logic [DEPTH-1:0]  sync_q;
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[DEPTH-2:0], req_tgl_i};
  end

  assign set_o = sync_q[DEPTH-1] ^ sync_q[DEPTH-2];

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (set_o) begin
      full_q <= 1'b1;
      data_q <= word_i;
    end else if (clr_i) begin
      full_q <= 1'b0;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;
endmodule

// File: rtl/mbox_xdomain_flags.sv
module mbox_xdomain_flags #(
  parameter int unsigned              N_MBOX     = 2,
  parameter int unsigned              ADDR_W     = 4,
  parameter int unsigned              DATA_W     = 16,
  parameter logic [N_MBOX*ADDR_W-1:0] MBOX_ADDRS = {4'h3, 4'h2}
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     bus_cmd_i,
  input  logic                     bus_op_i,
  input  logic                     bus_wr_ni,
  input  logic [ADDR_W-1:0]        bus_addr_i,
  input  logic [DATA_W-1:0]        bus_data_i,
  input  logic [N_MBOX-1:0]        clr_i,
  output logic [N_MBOX-1:0]        set_pulse_o,
  output logic [N_MBOX-1:0]        full_o,
  output logic [N_MBOX*DATA_W-1:0] data_o
);
  import mbox_pkg::*;

  localparam int unsigned DEPTH = SYNC_DEPTH;

  logic [N_MBOX-1:0]        tgl;
  logic [N_MBOX*DATA_W-1:0] word;

  for (genvar g = 0; g < N_MBOX; g++) begin : g_mbox
    mbox_bus_capture #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .MY_ADDR(MBOX_ADDRS[g*ADDR_W +: ADDR_W])
    ) i_cap (
      .bus_cmd_i (bus_cmd_i),
      .rst_ni    (rst_ni),
      .bus_op_i  (bus_op_i),
      .bus_wr_ni (bus_wr_ni),
      .bus_addr_i(bus_addr_i),
      .bus_data_i(bus_data_i),
      .req_tgl_o (tgl[g]),
      .word_o    (word[g*DATA_W +: DATA_W])
    );

    mbox_flag_sync #(
      .DATA_W(DATA_W),
      .DEPTH (DEPTH)
    ) i_sync (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_tgl_i(tgl[g]),
      .word_i   (word[g*DATA_W +: DATA_W]),
      .clr_i    (clr_i[g]),
      .set_o    (set_pulse_o[g]),
      .full_o   (full_o[g]),
      .data_o   (data_o[g*DATA_W +: DATA_W])
    );
  end
endmodule

// File: rtl/mbox_xdomain_flags_chk.sv
module mbox_xdomain_flags_chk #(
  parameter int unsigned N_MBOX = 2,
  parameter int unsigned DATA_W = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [N_MBOX-1:0]        clr_i,
  input logic [N_MBOX-1:0]        set_pulse_o,
  input logic [N_MBOX-1:0]        full_o,
  input logic [N_MBOX*DATA_W-1:0] data_o
);
  for (genvar g = 0; g < N_MBOX; g++) begin : g_chk
    a_r3_set_fills: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_pulse_o[g] |=> full_o[g]);

    a_r8_set_beats_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_pulse_o[g] && clr_i[g]) |=> full_o[g]);

    a_r7_clr_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !set_pulse_o[g]) |=> !full_o[g]);

    a_r3_flag_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i[g] && !set_pulse_o[g]) |=> $stable(full_o[g]));

    a_r9_word_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !set_pulse_o[g] |=> $stable(data_o[g*DATA_W +: DATA_W]));
  end

  always_comb begin
    if (!rst_ni) begin
      a_r1_reset_quiet: assert (full_o == '0 && set_pulse_o == '0);
    end
  end
endmodule

bind mbox_xdomain_flags mbox_xdomain_flags_chk #(
  .N_MBOX(N_MBOX),
  .DATA_W(DATA_W)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_i      (clr_i),
  .set_pulse_o(set_pulse_o),
  .full_o     (full_o),
  .data_o     (data_o)
);

// File: tb/test_mbox_xdomain_flags.sv
module test_mbox_xdomain_flags;
  localparam int N = 2;
  localparam int AW = 4;
  localparam int DW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          bus_cmd_i = 1'b0;
  logic          bus_op_i = 1'b0;
  logic          bus_wr_ni = 1'b1;
  logic [AW-1:0] bus_addr_i = '0;
  logic [DW-1:0] bus_data_i = '0;
  logic [N-1:0]  clr_i = '0;
  logic [N-1:0]  set_pulse_o;
  logic [N-1:0]  full_o;
  logic [N*DW-1:0] data_o;

  mbox_xdomain_flags i_mbox_xdomain_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_cmd_i(bus_cmd_i), .bus_op_i(bus_op_i),
    .bus_wr_ni(bus_wr_ni), .bus_addr_i(bus_addr_i), .bus_data_i(bus_data_i),
    .clr_i(clr_i), .set_pulse_o(set_pulse_o), .full_o(full_o), .data_o(data_o)
  );

  always #10 clk_i = ~clk_i;  // 50 MHz

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  // reference model state
  logic [N-1:0]  m_full = '0;
  logic [DW-1:0] m_data [N];
  logic [DW-1:0] m_bus  [N];
  logic [N-1:0]  m_clr_prev = '0;
  logic [N-1:0]  due_mask [int];
  int            mb_addr [N] = '{2, 3};

  task automatic chk(string tag, string what, int k, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s mb%0d at cycle %0d: actual %h expected %h", tag, what, k, cyc, act, exp);
    end
  endtask

  // one main clock cycle: update model for the edge just past, compare, then drive
  task automatic step(string tag, bit stb, bit op, bit wr_n, int addr, logic [DW-1:0] d,
                      logic [N-1:0] clr);
    logic [N-1:0] pm;
    @(negedge clk_i); #1;
    pm = due_mask.exists(cyc - 1) ? due_mask[cyc - 1] : '0;
    for (int k = 0; k < N; k++) begin
      if (pm[k]) begin
        m_full[k] = 1'b1;       // R8: set wins over a clear on the same edge
        m_data[k] = m_bus[k];   // R9
      end else if (m_clr_prev[k]) begin
        m_full[k] = 1'b0;       // R7
      end
    end
    pm = due_mask.exists(cyc) ? due_mask[cyc] : '0;
    for (int k = 0; k < N; k++) begin
      chk(tag, "R2 pulse", k, DW'(set_pulse_o[k]), DW'(pm[k]));
      chk(tag, "R3 full", k, DW'(full_o[k]), DW'(m_full[k]));
      chk(tag, "R9 data", k, data_o[k*DW +: DW], m_data[k]);
    end
    m_clr_prev = clr;
    bus_cmd_i  = 1'b0;
    bus_op_i   = op;
    bus_wr_ni  = wr_n;
    bus_addr_i = AW'(addr);
    bus_data_i = d;
    clr_i      = clr;
    #2;
    bus_cmd_i = stb;
    if (stb && op && !wr_n) begin
      for (int k = 0; k < N; k++) begin
        if (addr == mb_addr[k]) begin
          m_bus[k] = d;
          if (!due_mask.exists(cyc + 2)) due_mask[cyc + 2] = '0;
          due_mask[cyc + 2][k] = 1'b1;
        end
      end
    end
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 1, 0, '0, '0);
  endtask

  task automatic wr(string tag, int addr, logic [DW-1:0] d);
    step(tag, 1, 1, 0, addr, d, '0);
  endtask

  initial begin
    for (int k = 0; k < N; k++) begin m_data[k] = '0; m_bus[k] = '0; end
    #35;
    for (int k = 0; k < N; k++) begin
      chk("R1", "reset full", k, DW'(full_o[k]), '0);
      chk("R1", "reset pulse", k, DW'(set_pulse_o[k]), '0);
      chk("R1", "reset data", k, data_o[k*DW +: DW], '0);
    end
    @(negedge clk_i); rst_ni = 1'b1;
    idle("R1", 2);

    wr("R2", 2, 16'hA5A5);           // attention write
    idle("R3", 5);
    step("R7", 0, 0, 1, 0, '0, 2'b01);
    idle("R7", 3);
    step("R7", 0, 0, 1, 0, '0, 2'b01); // clear of an empty flag
    idle("R7", 2);

    step("R4", 1, 1, 1, 2, 16'hDEAD, '0);  // read of attention
    step("R4", 1, 1, 1, 3, 16'hDEAD, '0);  // read of command
    idle("R4", 4);
    step("R5", 1, 0, 0, 2, 16'hBEEF, '0);  // no operation
    step("R5", 1, 0, 0, 3, 16'hBEEF, '0);
    idle("R5", 4);
    wr("R6", 5, 16'h1111);
    wr("R6", 0, 16'h2222);
    idle("R6", 2);
    wr("R6", 3, 16'h1234);           // command only
    idle("R6", 5);

    wr("R8", 2, 16'h0F0F);
    idle("R8", 5);
    wr("R8", 2, 16'h0BEE);
    idle("R8", 1);
    step("R8", 0, 0, 1, 0, '0, 2'b01); // clear lands with the set
    idle("R8", 4);
    step("R9", 0, 0, 1, 0, '0, 2'b11); // clear leaves data untouched
    idle("R9", 3);

    wr("R10", 2, 16'hC001);          // attention then command at once
    wr("R10", 3, 16'hC002);
    wr("R10", 3, 16'hC003);
    idle("R10", 12);
    step("R10", 0, 0, 1, 0, '0, 2'b11);
    idle("R10", 3);
    wr("R10", 3, 16'h7777);
    wr("R10", 2, 16'h8888);
    idle("R10", 6);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule